// File: doc/BRIEF.md
# Half-Duplex Serial Register Port

This block is the peripheral end of a two-wire synchronous serial link. A host supplies a serial clock and shares one bidirectional data line with it. Every transaction is sixteen rising clock edges long. The first bit sets the direction, the next seven bits give a register address, and the last eight bits carry data. On a write the block collects the data byte and updates a small register file. On a read it takes over the data line and shifts the addressed register out. The serial clock idles high.

Both serial pins are brought into the system clock domain through a two-flop synchroniser, and edges are detected there. Address and data are sent most significant bit first. A watchdog counts system clocks from the first rising edge of a transaction. If the transaction has not finished before the limit, the port drops back to idle, so that a host that has fallen out of step can recover by waiting. The data line is driven through a separate output value and output enable, which feed an external tri-state pad.

The register map has 0x00 as a read-only identifier, 0x01 as a read-only status byte, and `NUM_RW` read/write configuration bytes starting at 0x02. The controller has six states. IDLE goes to ADDR on a rising edge. ADDR goes to WDATA (direction 1) or TURN (direction 0) on the eighth rising edge. WDATA goes to IDLE on the sixteenth. TURN goes to RDATA on the ninth. RDATA goes to HOLD on the sixteenth. HOLD goes to IDLE on the next falling edge. An expired watchdog sends any state to IDLE.

Top module: `sreg_port`

## Requirements
- R1: While `rst_n` is low and right after it is released, `sdio_oe` is 0 and every configuration byte on `cfg_o` is 0x00.
- R2: A transaction whose first bit is 1 is a write. After its sixteenth rising edge, the data byte is stored in the register at the sent address. For addresses 0x02 to 0x02+NUM_RW-1, that register appears on `cfg_o[8*(addr-2) +: 8]`.
- R3: A write to address 0x00, 0x01 or any address at or above 0x02+NUM_RW leaves `cfg_o` unchanged.
- R4: A transaction whose first bit is 0 is a read. The addressed byte is driven on `sdio_o` most significant bit first. Bit 7-k is valid from shortly after rising edge 9+k until rising edge 10+k, or for bit 0 until the falling edge after edge 16. A read of a configuration address returns the last value written there.
- R5: A read of 0x00 returns `ID_VALUE`. A read of 0x01 returns {3'b000, `stat_i`}, so its upper three bits are zero.
- R6: A read of any address at or above 0x02+NUM_RW returns 0x00.
- R7: `sdio_oe` stays 0 for the whole of a write. During a read it stays 0 until the ninth rising edge.
- R8: After a read, `sdio_oe` returns to 0 within 5 system clocks of the falling serial clock edge that follows the sixteenth rising edge.
- R9: If the sixteenth rising edge has not arrived `WD_CYCLES` system clocks after the first one, the port returns to idle. A partial write changes nothing, `sdio_oe` goes to 0, and the next rising edge begins a new transaction.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sck_i | input | 1 | Serial clock from the host, idles high |
| sdio_i | input | 1 | Data line as seen at the pad input |
| sdio_o | output | 1 | Value to drive onto the data line |
| sdio_oe | output | 1 | Output enable for the data line pad |
| stat_i | input | 5 | Status bits returned in the low bits of register 0x01 |
| cfg_o | output | NUM_RW*8 | Read/write configuration bytes, byte i at address 0x02+i |

## Verification
If the bit counter or state register is off by one, the port no longer lines up with the sixteen-edge frame. This shows within one transaction as a byte written to the neighbouring address, or as read data shifted by one place on `sdio_o`. A wrong direction latch or turnaround state shows as `sdio_oe` asserting during a write or before the ninth edge, which the bench samples just before that edge. A watchdog that does not clear or fire leaves a stalled write able to complete later, or leaves the data line driven. Both of these appear at the ports after the first transaction that follows the stall.

// File: rtl/sreg_pkg.sv
package sreg_pkg;
    localparam int unsigned ADDR_W = 7;
    localparam int unsigned DATA_W = 8;
    localparam int unsigned STAT_W = DATA_W - 3;
    localparam int unsigned FRAME_LEN = 1 + ADDR_W + DATA_W;
    localparam int unsigned CNT_W = $clog2(FRAME_LEN);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_WDATA,
        ST_TURN,
        ST_RDATA,
        ST_HOLD
    } port_state_t;
endpackage

// File: rtl/sreg_sync.sv
module sreg_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic sck_i,
    input  logic sdio_i,
    output logic sck_rise,
    output logic sck_fall,
    output logic sdio_s
);
    logic [1:0] sck_ff;
    logic [1:0] dat_ff;
    logic       sck_prev;

    // Pins idle high; reset to that level so release of reset is not an edge.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sck_ff   <= 2'b11;
            dat_ff   <= 2'b11;
            sck_prev <= 1'b1;
        end else begin
            sck_ff   <= {sck_ff[0], sck_i};
            dat_ff   <= {dat_ff[0], sdio_i};
            sck_prev <= sck_ff[1];
        end
    end

    assign sck_rise = sck_ff[1] & ~sck_prev;
    assign sck_fall = ~sck_ff[1] & sck_prev;
    assign sdio_s   = dat_ff[1];
endmodule

// File: rtl/sreg_wdog.sv
module sreg_wdog #(
    parameter int unsigned LIMIT = 4_500_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic expire
);
    localparam int unsigned W = $clog2(LIMIT + 1);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (!run || expire)
            cnt_q <= '0;
        else
            cnt_q <= cnt_q + 1'b1;
    end

    assign expire = run && (cnt_q == W'(LIMIT - 1));

    AST_WD_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (cnt_q < W'(LIMIT))); // R9
endmodule

// File: rtl/sreg_regs.sv
module sreg_regs
    import sreg_pkg::*;
#(
    parameter int unsigned NUM_RW   = 4,
    parameter int unsigned RW_BASE  = 2,
    parameter logic [DATA_W-1:0] ID_VALUE = 8'h5A
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [ADDR_W-1:0]        wr_addr,
    input  logic [DATA_W-1:0]        wr_data,
    input  logic [ADDR_W-1:0]        rd_addr,
    input  logic [STAT_W-1:0]        stat_i,
    output logic [DATA_W-1:0]        rd_data,
    output logic [NUM_RW*DATA_W-1:0] cfg_o
);
    logic [DATA_W-1:0] regs_q [NUM_RW];

    for (genvar i = 0; i < NUM_RW; i++) begin : g_rw
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                regs_q[i] <= '0;
            else if (wr_en && (wr_addr == ADDR_W'(RW_BASE + i)))
                regs_q[i] <= wr_data;
        end
        assign cfg_o[i*DATA_W +: DATA_W] = regs_q[i];
    end

    always_comb begin
        rd_data = '0;
        if (rd_addr == ADDR_W'(0))
            rd_data = ID_VALUE;
        else if (rd_addr == ADDR_W'(1))
            rd_data = {3'b000, stat_i};
        else begin
            for (int i = 0; i < NUM_RW; i++) begin
                if (rd_addr == ADDR_W'(RW_BASE + i))
                    rd_data = regs_q[i];
            end
        end
    end

    AST_BAD_WR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && ((int'(wr_addr) < RW_BASE) || (int'(wr_addr) >= RW_BASE + NUM_RW)))
        |=> $stable(cfg_o)); // R3
endmodule

// File: rtl/sreg_port.sv
module sreg_port
    import sreg_pkg::*;
#(
    parameter int unsigned WD_CYCLES = 4_500_000,
    parameter int unsigned NUM_RW    = 4,
    parameter logic [7:0]  ID_VALUE  = 8'h5A
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     sck_i,
    input  logic                     sdio_i,
    output logic                     sdio_o,
    output logic                     sdio_oe,
    input  logic [STAT_W-1:0]        stat_i,
    output logic [NUM_RW*DATA_W-1:0] cfg_o
);
    localparam logic [CNT_W-1:0] ADDR_LAST = CNT_W'(ADDR_W);
    localparam logic [CNT_W-1:0] BIT_LAST  = CNT_W'(FRAME_LEN - 1);

    port_state_t       state_q, state_d;
    logic [CNT_W-1:0]  bit_q;
    logic              dir_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] sh_q;
    logic              oe_q;
    logic              sck_rise, sck_fall, sdio_s;
    logic              wd_expire;
    logic              wr_en;
    logic [DATA_W-1:0] rd_data;

    sreg_sync u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .sck_i    (sck_i),
        .sdio_i   (sdio_i),
        .sck_rise (sck_rise),
        .sck_fall (sck_fall),
        .sdio_s   (sdio_s)
    );

    sreg_wdog #(.LIMIT(WD_CYCLES)) u_wdog (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (state_q != ST_IDLE),
        .expire (wd_expire)
    );

    assign wr_en = (state_q == ST_WDATA) && sck_rise && (bit_q == BIT_LAST) && !wd_expire;

    sreg_regs #(.NUM_RW(NUM_RW), .RW_BASE(2), .ID_VALUE(ID_VALUE)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (addr_q),
        .wr_data ({sh_q[DATA_W-2:0], sdio_s}),
        .rd_addr (addr_q),
        .stat_i  (stat_i),
        .rd_data (rd_data),
        .cfg_o   (cfg_o)
    );

    // Next-state logic
    always_comb begin
        state_d = state_q;
        if (wd_expire) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE:  if (sck_rise) state_d = ST_ADDR;
                ST_ADDR:  if (sck_rise && bit_q == ADDR_LAST)
                              state_d = dir_q ? ST_WDATA : ST_TURN;
                ST_WDATA: if (sck_rise && bit_q == BIT_LAST) state_d = ST_IDLE;
                ST_TURN:  if (sck_rise) state_d = ST_RDATA;
                ST_RDATA: if (sck_rise && bit_q == BIT_LAST) state_d = ST_HOLD;
                ST_HOLD:  if (sck_fall) state_d = ST_IDLE;
                default:  state_d = ST_IDLE;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Shift, count and pad control
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_q  <= '0;
            dir_q  <= 1'b0;
            addr_q <= '0;
            sh_q   <= '0;
            oe_q   <= 1'b0;
        end else if (wd_expire) begin
            bit_q <= '0;
            oe_q  <= 1'b0;
        end else if (sck_rise) begin
            unique case (state_q)
                ST_IDLE: begin
                    dir_q <= sdio_s;
                    bit_q <= CNT_W'(1);
                end
                ST_ADDR: begin
                    addr_q <= {addr_q[ADDR_W-2:0], sdio_s};
                    bit_q  <= bit_q + 1'b1;
                end
                ST_WDATA: begin
                    sh_q  <= {sh_q[DATA_W-2:0], sdio_s};
                    bit_q <= bit_q + 1'b1;
                end
                ST_TURN: begin
                    sh_q  <= rd_data;
                    oe_q  <= 1'b1;
                    bit_q <= bit_q + 1'b1;
                end
                ST_RDATA: begin
                    sh_q  <= {sh_q[DATA_W-2:0], 1'b0};
                    bit_q <= bit_q + 1'b1;
                end
                default: ;
            endcase
        end else if (sck_fall && state_q == ST_HOLD) begin
            oe_q <= 1'b0;
        end
    end

    assign sdio_oe = oe_q;
    assign sdio_o  = oe_q & sh_q[DATA_W-1];

    AST_OE_READ_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        sdio_oe |-> !dir_q); // R7
    AST_NO_WR_WHILE_OE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> !sdio_oe); // R7
    AST_OE_START_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sdio_oe) |-> $past(sck_rise)); // R4
    AST_OE_STOP_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sdio_oe) |-> ($past(sck_fall) || $past(wd_expire))); // R8
    AST_WD_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        wd_expire |=> (state_q == ST_IDLE && !sdio_oe)); // R9
endmodule

// File: tb/test_sreg_port.sv
module test_sreg_port;
    localparam int WD   = 2000;
    localparam int H    = 8;
    localparam int NRW  = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sck = 1'b1;
    logic        sdio = 1'b1;
    logic        sdio_o;
    logic        sdio_oe;
    logic [4:0]  stat = 5'h1B;
    logic [NRW*8-1:0] cfg;

    int checks = 0;
    int failures = 0;
    logic [7:0] exp_q[$];
    string      tag_q[$];

    always #10 clk = ~clk;

    sreg_port #(.WD_CYCLES(WD), .NUM_RW(NRW), .ID_VALUE(8'h5A)) i_sreg_port (
        .clk     (clk),
        .rst_n   (rst_n),
        .sck_i   (sck),
        .sdio_i  (sdio),
        .sdio_o  (sdio_o),
        .sdio_oe (sdio_oe),
        .stat_i  (stat),
        .cfg_o   (cfg)
    );

    task automatic check(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic put_bit(input logic b);
        sck = 1'b0;
        sdio = b;
        wait_clk(H);
        sck = 1'b1;
        wait_clk(H);
    endtask

    task automatic send_hdr(input logic dir, input logic [6:0] a);
        put_bit(dir);
        for (int i = 6; i >= 0; i--) put_bit(a[i]);
    endtask

    task automatic wr(input logic [6:0] a, input logic [7:0] d);
        send_hdr(1'b1, a);
        for (int i = 7; i >= 0; i--) begin
            put_bit(d[i]);
            check(sdio_oe == 1'b0, "R7 oe during write", 32'(sdio_oe), 0);
        end
        wait_clk(H);
    endtask

    task automatic rd(input logic [6:0] a, input logic [7:0] exp, input string tag);
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        send_hdr(1'b0, a);
        check(sdio_oe == 1'b0, "R7 oe before edge 9", 32'(sdio_oe), 0);
        for (int i = 0; i < 8; i++) begin
            put_bit(1'b0);
            if (i == 0) check(sdio_oe == 1'b1, "R4 oe after edge 9", 32'(sdio_oe), 1);
        end
        sck = 1'b0;
        wait_clk(5);
        check(sdio_oe == 1'b0, "R8 oe release", 32'(sdio_oe), 0);
        wait_clk(H - 5);
    endtask

    // Monitor: sample the driven line on each falling serial clock edge
    initial begin
        int n;
        logic done;
        logic [7:0] got;
        logic [7:0] e;
        string t;
        n = 0;
        done = 1'b0;
        got = '0;
        forever begin
            @(negedge sck);
            if (!sdio_oe) begin
                n = 0;
                done = 1'b0;
            end else if (!done) begin
                got = {got[6:0], sdio_o};
                n++;
                if (n == 8) begin
                    done = 1'b1;
                    if (exp_q.size() == 0) begin
                        check(1'b0, "R4 unexpected read", 32'(got), 0);
                    end else begin
                        e = exp_q.pop_front();
                        t = tag_q.pop_front();
                        check(got == e, t, 32'(got), 32'(e));
                    end
                end
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        wait_clk(3);
        check(sdio_oe == 1'b0, "R1 oe in reset", 32'(sdio_oe), 0);
        rst_n = 1'b1;
        wait_clk(4);
        check(sdio_oe == 1'b0, "R1 oe after reset", 32'(sdio_oe), 0);
        check(cfg == '0, "R1 cfg after reset", cfg, 0);

        wr(7'h02, 8'hA5);
        check(cfg == 32'h0000_00A5, "R2 write 0x02", cfg, 32'h0000_00A5);
        wr(7'h05, 8'h3C);
        check(cfg == 32'h3C00_00A5, "R2 write 0x05", cfg, 32'h3C00_00A5);
        wr(7'h03, 8'h81);
        check(cfg == 32'h3C00_81A5, "R2 write 0x03", cfg, 32'h3C00_81A5);

        wr(7'h00, 8'hFF);
        check(cfg == 32'h3C00_81A5, "R3 write 0x00", cfg, 32'h3C00_81A5);
        wr(7'h01, 8'hFF);
        check(cfg == 32'h3C00_81A5, "R3 write 0x01", cfg, 32'h3C00_81A5);
        wr(7'h06, 8'hFF);
        check(cfg == 32'h3C00_81A5, "R3 write 0x06", cfg, 32'h3C00_81A5);
        wr(7'h7F, 8'h00);
        check(cfg == 32'h3C00_81A5, "R3 write 0x7F", cfg, 32'h3C00_81A5);

        rd(7'h00, 8'h5A, "R5 read id");
        rd(7'h01, 8'h1B, "R5 read status");
        stat = 5'h05;
        rd(7'h01, 8'h05, "R5 read status 2");
        rd(7'h02, 8'hA5, "R4 read 0x02");
        rd(7'h05, 8'h3C, "R4 read 0x05");
        rd(7'h03, 8'h81, "R4 read 0x03");
        rd(7'h06, 8'h00, "R6 read 0x06");
        rd(7'h7F, 8'h00, "R6 read 0x7F");

        // R9: stalled write after 10 edges must not complete
        send_hdr(1'b1, 7'h04);
        put_bit(1'b1);
        put_bit(1'b1);
        wait_clk(WD + 100);
        wr(7'h04, 8'h77);
        check(cfg == 32'h3C77_81A5, "R9 stalled write dropped", cfg, 32'h3C77_81A5);

        // R9: stalled read releases the line
        send_hdr(1'b0, 7'h02);
        put_bit(1'b0);
        put_bit(1'b0);
        put_bit(1'b0);
        check(sdio_oe == 1'b1, "R9 oe mid read", 32'(sdio_oe), 1);
        wait_clk(WD + 100);
        check(sdio_oe == 1'b0, "R9 oe after timeout", 32'(sdio_oe), 0);
        rd(7'h04, 8'h77, "R9 read after timeout");

        wait_clk(4 * H);
        check(exp_q.size() == 0, "R4 all reads seen", 32'(exp_q.size()), 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule